// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block runs one complete readout of a linear photodiode array whose pixels are digitised by a pipelined 16-bit ADC and stored in a FIFO. A host raises one start line. From then on the sequencer does all of the timing. It produces a frame-start pulse for the detector, clears the FIFO write pointer, and then clocks the detector pixel by pixel while it clocks the ADC in step. Because the ADC delivers each conversion a fixed number of conversion clocks after its pixel is sampled, the FIFO write strobe stays off until the first valid word arrives. After that the block writes exactly one word per pixel.

When the last word has been written, the ADC is clocked a few more periods so its pipeline drains. The block then reports completion with a one-cycle pulse and a sticky flag. The pixel clock is obtained by dividing the system clock, so one pixel period lasts `2*HALF_DIV` system cycles. With the default values, a 64 MHz system clock gives an 8 MHz pixel rate.

Top module: `linsens_readout_seq`

## Requirements
- R1: A rising edge on `start_i` while idle is accepted through a two-flop synchronizer and edge detector. `busy_o` reads 1 after exactly the third rising clock edge that follows the change on `start_i`.
- R2: A rising edge on `start_i` while `busy_o` is 1 is ignored. The frame runs to its single `done_o` pulse, and `busy_o` stays 0 after it.
- R3: `det_frame_o` and `fifo_rst_o` are both 1 for exactly one pixel period (`2*HALF_DIV` cycles) at the start of the frame. This happens before the first pixel clock pulse.
- R4: `det_pix_clk_o` produces exactly `NUM_PIX` pulses, one per pixel period. Each pulse is 1 for `HALF_DIV` cycles (the first half of its period).
- R5: `adc_clk_o` produces exactly `NUM_PIX + 2*ADC_LAT` pulses, one per pixel period, each in the first half of its period.
- R6: `fifo_we_o` produces exactly `NUM_PIX` one-cycle strobes, each in the last cycle of a pixel period. No strobe occurs during the first `ADC_LAT` ADC clock periods. The first strobe falls in the period of ADC clock pulse number `ADC_LAT+1`.
- R7: After the last write strobe, exactly `ADC_LAT` further ADC clock pulses occur before `done_o`.
- R8: `done_o` is a single-cycle pulse, and `busy_o` is 0 while it is high. `busy_o` is 1 for exactly `2*HALF_DIV*(1 + NUM_PIX + 2*ADC_LAT)` cycles per frame.
- R9: `done_flag_o` is set by `done_o` and reads 0 from the cycle `busy_o` rises.
- R10: While reset is held, and after it is released, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Host start request, asynchronous; rising edge launches a frame |
| det_pix_clk_o | output | 1 | Detector pixel clock |
| det_frame_o | output | 1 | Detector frame-start pulse, one pixel period |
| adc_clk_o | output | 1 | ADC conversion clock |
| fifo_rst_o | output | 1 | FIFO write-pointer reset |
| fifo_we_o | output | 1 | FIFO write strobe, one cycle per valid word |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle frame completion pulse |
| done_flag_o | output | 1 | Sticky completion flag, cleared by the next accepted start |

## Verification
The bench keeps the full 128-pixel array and the 7-period ADC latency, so the real write window and the drain window are checked pulse by pulse. It sets `HALF_DIV` to 3, which gives a 6-cycle pixel period with an odd half-period. This short period keeps each frame to under a thousand cycles. It also makes an off-by-one in the divider, in the latency gate or in the flush count show up directly in the pulse counts and widths. Restart edges are injected inside the frame, at different points and with different start-hold lengths, to exercise the busy lockout.

// File: rtl/linsens_pkg.sv
package linsens_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FRAME = 2'd1,
    SQ_READ  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/linsens_start_sync.sv
module linsens_start_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= start_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;

  // R1: an edge lasts one cycle only
  p_rise_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/linsens_pix_timer.sv
module linsens_pix_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o,
  output logic hi_o
);
  localparam int PER = 2 * HALF_DIV;
  localparam int PW  = (PER > 1) ? $clog2(PER) : 1;
  localparam logic [PW-1:0] LAST = PW'(PER - 1);
  localparam logic [PW-1:0] HALF = PW'(HALF_DIV);

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!en_i)              phase_d = '0;
    else if (phase_q == LAST) phase_d = '0;
    else                    phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  assign tick_o = en_i && (phase_q == LAST);
  assign hi_o   = en_i && (phase_q < HALF);

  // R4: the period end always lies in the low half
  p_tick_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> !hi_o);
  // R4: the high half is entered only from a period start
  p_hi_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_o) |-> phase_q == '0);
endmodule

// File: rtl/linsens_readout_seq.sv
module linsens_readout_seq #(
  parameter int NUM_PIX  = 128,
  parameter int ADC_LAT  = 7,
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic det_pix_clk_o,
  output logic det_frame_o,
  output logic adc_clk_o,
  output logic fifo_rst_o,
  output logic fifo_we_o,
  output logic busy_o,
  output logic done_o,
  output logic done_flag_o
);
  import linsens_pkg::*;

  localparam int TOTAL = NUM_PIX + 2 * ADC_LAT;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TOTAL - 1);
  localparam logic [CW-1:0] PIX_END  = CW'(NUM_PIX);
  localparam logic [CW-1:0] WR_BEG   = CW'(ADC_LAT);
  localparam logic [CW-1:0] WR_END   = CW'(ADC_LAT + NUM_PIX);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic start_rise, tick, hi, tmr_en;

  linsens_start_sync i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (start_i),
    .rise_o  (start_rise)
  );

  linsens_pix_timer #(.HALF_DIV(HALF_DIV)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .en_i   (tmr_en),
    .tick_o (tick),
    .hi_o   (hi)
  );

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          flag_q, flag_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    flag_d  = flag_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_rise) begin
          state_d = SQ_FRAME;
          flag_d  = 1'b0;
        end
      end
      SQ_FRAME: begin
        if (tick) begin
          state_d = SQ_READ;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      SQ_READ: begin
        if (tick) begin
          cnt_en = 1'b1;
          if (cnt_q == CNT_LAST) begin
            state_d = SQ_IDLE;
            done_d  = 1'b1;
            flag_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      flag_q  <= flag_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  logic in_read;
  assign in_read = (state_q == SQ_READ);
  assign tmr_en  = (state_q != SQ_IDLE);

  assign busy_o        = tmr_en;
  assign done_o        = done_q;
  assign done_flag_o   = flag_q;
  assign det_frame_o   = (state_q == SQ_FRAME);
  assign fifo_rst_o    = (state_q == SQ_FRAME);
  assign det_pix_clk_o = in_read && hi && (cnt_q < PIX_END);
  assign adc_clk_o     = in_read && hi;
  assign fifo_we_o     = in_read && tick && (cnt_q >= WR_BEG) && (cnt_q < WR_END);

  // R1: a frame begins only after a synchronized start edge
  p_busy_from_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_rise));
  // R2: once reading, the frame phase is never re-entered
  p_no_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_read |=> state_q != SQ_FRAME);
  // R3: pixel clock and writes stay off during frame start
  p_frame_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    det_frame_o |-> !det_pix_clk_o && !fifo_we_o && !adc_clk_o);
  // R6: writes only while busy and on a low ADC clock
  p_we_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    fifo_we_o |-> busy_o && !adc_clk_o);
  // R8: done comes with busy low and never twice in a row
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> !busy_o ##1 !done_o);
  // R9: the sticky flag is set by done
  p_flag_set_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> done_flag_o);
  // R9: the flag is clear when a frame starts
  p_flag_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(busy_o) |-> !done_flag_o);
endmodule

// File: tb/test_linsens_readout_seq.sv
module test_linsens_readout_seq;
  localparam int NUM_PIX  = 128;
  localparam int ADC_LAT  = 7;
  localparam int HALF_DIV = 3;
  localparam int PER      = 2 * HALF_DIV;
  localparam int TOTAL    = NUM_PIX + 2 * ADC_LAT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic pix, frm, adc, frst, we, busy, done, flag;

  always #2.5 clk = ~clk;

  linsens_readout_seq #(.NUM_PIX(NUM_PIX), .ADC_LAT(ADC_LAT), .HALF_DIV(HALF_DIV))
    i_linsens_readout_seq (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_i       (start),
    .det_pix_clk_o (pix),
    .det_frame_o   (frm),
    .adc_clk_o     (adc),
    .fifo_rst_o    (frst),
    .fifo_we_o     (we),
    .busy_o        (busy),
    .done_o        (done),
    .done_flag_o   (flag)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // vectors: start hold length, restart-glitch cycle (0 = none)
  localparam int NV = 3;
  localparam int HOLD [NV] = '{2, 40, 1000};
  localparam int GLT  [NV] = '{0, 300, 500};

  task automatic run_frame(int hold, int glitch);
    int busy_first = -1, busy_cnt = 0, frame_cnt = 0, rst_cnt = 0;
    int pix_rise = 0, pix_early = 0, adc_rise = 0, we_cnt = 0;
    int adc_before_we = -1, adc_after = 0, done_cnt = 0;
    int hi_run = 0, hi_min = 1 << 20, hi_max = 0, post = 0, post_busy = 0;
    int flag_accept = 1, busy_at_done = 1;
    bit frame_over = 0, p_prev = 0, a_prev = 0;
    start = 1'b1;
    for (int c = 1; c <= 3000; c++) begin
      @(negedge clk);
      if (busy && busy_first < 0) begin
        busy_first  = c;
        flag_accept = int'(flag);
      end
      if (done_cnt > 0) begin
        post++;
        post_busy += int'(busy);
      end else begin
        busy_cnt += int'(busy);
      end
      if (frm) frame_cnt++;
      else if (frame_cnt > 0) frame_over = 1;
      if (frst) rst_cnt++;
      if (pix && !p_prev) begin
        pix_rise++;
        if (!frame_over) pix_early++;
      end
      if (pix) hi_run++;
      else if (p_prev) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
        hi_run = 0;
      end
      if (adc && !a_prev) begin
        adc_rise++;
        if (we_cnt > 0) adc_after++;
      end
      if (we) begin
        we_cnt++;
        if (we_cnt == 1) adc_before_we = adc_rise;
        adc_after = 0;
      end
      if (done) begin
        done_cnt++;
        busy_at_done = int'(busy);
      end
      p_prev = pix;
      a_prev = adc;
      if (c == hold) start = 1'b0;
      if (glitch > 0 && (c == glitch || c == glitch + 4)) start = ~start;
      if (post == 40) break;
    end
    if (done_cnt == 0) begin
      errors++;
      $display("FAIL watchdog R8 actual %0d expected %0d", 0, 1);
    end
    chk(busy_first, 3, "R1 busy latency");
    chk(flag_accept, 0, "R9 flag clear at accept");
    chk(frame_cnt, PER, "R3 frame width");
    chk(rst_cnt, PER, "R3 fifo reset width");
    chk(pix_early, 0, "R3 pixel clock before frame end");
    chk(pix_rise, NUM_PIX, "R4 pixel pulses");
    chk(hi_min, HALF_DIV, "R4 pixel high min");
    chk(hi_max, HALF_DIV, "R4 pixel high max");
    chk(adc_rise, TOTAL, "R5 adc pulses");
    chk(we_cnt, NUM_PIX, "R6 write strobes");
    chk(adc_before_we, ADC_LAT + 1, "R6 first write position");
    chk(adc_after, ADC_LAT, "R7 flush pulses");
    chk(done_cnt, 1, "R8 done pulses");
    chk(busy_at_done, 0, "R8 busy with done");
    chk(busy_cnt, PER * (1 + TOTAL), "R8 busy length");
    chk(int'(flag), 1, "R9 flag after done");
    chk(post_busy, 0, "R2 no restart after done");
    start = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    chk(int'({pix, frm, adc, frst, we, busy, done, flag}), 0, "R10 in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(int'({pix, frm, adc, frst, we, busy, done, flag}), 0, "R10 after reset");
    for (int v = 0; v < NV; v++) run_frame(HOLD[v], GLT[v]);
    // R2: start edge during drain window is ignored
    start = 1'b1;
    repeat (3 + PER * (1 + TOTAL) - 10) @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1;
    repeat (30) @(negedge clk);
    chk(int'(busy), 0, "R2 edge in drain ignored");
    chk(int'(flag), 1, "R9 flag held when idle");
    start = 1'b0;
    // R10: reset mid-frame returns everything to 0
    repeat (4) @(negedge clk);
    start = 1'b1;
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(int'({pix, frm, adc, frst, we, busy, done, flag}), 0, "R10 reset mid-frame");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R8 actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule